// File: doc/BRIEF.md
# HDLC Bit-Stuffing Transmit Framer

This block converts a stream of payload bytes into the raw octet stream that a synchronous B-channel line carries. It handles one frame per burst of input bytes, with the burst ending at the byte marked as last. For each frame it sends a 0x7E opening flag, then the payload with zero bits inserted, then a 16-bit frame check sequence and a 0x7E closing flag. If the frame does not end on an octet boundary, it pads the last octet with ones and appends one more all-ones octet. One line bit is serialized per clock whenever the output stage has room.

The `rate_56k` input selects the line format and is sampled once, when the first byte of a frame is accepted. When low, all 8 bits of every output octet carry line bits (64 kbit/s). When high, each output octet carries 7 line bits in positions 0 to 6 and bit 7 is forced to one (56 kbit/s). When no frame is in progress and the output register is empty, the block offers 0xFF filler octets to the consumer.

Control is a single state machine:
- IDLE accepts the first byte and moves to OPEN.
- OPEN sends the eight flag bits and moves to DATA.
- DATA serializes a byte. It moves to NEXT to fetch the following byte, or to FCS after the last byte.
- NEXT waits for the next input byte and returns to DATA.
- FCS serializes the 16 check bits and moves to CLOSE.
- CLOSE sends the closing flag and moves to PAD.
- PAD moves to EXTRA if a partial octet remains, or to IDLE if the frame is aligned.
- EXTRA emits the trailing 0xFF and returns to IDLE.

Top module: `hdlc_stuff_framer`

## Requirements
- R1: After reset, and whenever no frame is active, the output register is empty and `in_valid` is low, `out_valid` is 1, `out_data` is 0xFF and `in_ready` is 1. Filler octets carry no frame content.
- R2: The first line bits of every frame are the flag pattern 0x7E. In 64 kbit/s mode, the first output octet of a frame is exactly 0x7E.
- R3: Each byte is serialized least-significant bit first. Each line bit enters the top of the octet under assembly and earlier bits shift toward bit 0.
- R4: After five consecutive one bits of payload or check sequence, a zero bit is inserted and the run count restarts. A zero data bit also restarts the count. Flag bits are never stuffed and do not count.
- R5: The check sequence is the reflected CRC-16 with polynomial 0x8408, preset to 0xFFFF and computed over the payload bits. It is sent complemented, low byte first, LSB first.
- R6: With `rate_56k`=1, an octet is emitted after every 7 line bits. The bits sit in positions 0..6 and bit 7 is 1. The opening flag passes through the same 7-bit packing.
- R7: If the closing flag leaves k line bits (0<k<width) in a partial octet, that octet is emitted with the k bits in positions 0..k-1 and ones above, followed by one 0xFF octet. An aligned frame gets neither.
- R8: `rate_56k` is sampled only when a frame's first byte is accepted. Changes during a frame have no effect on that frame.
- R9: An octet offered with `out_ready` low stays valid and unchanged. No input byte is dropped or duplicated under any `out_ready` pattern.
- R10: After the byte marked `in_last` is accepted, `in_ready` is low in the following cycle and stays low until the frame has been fully serialized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_56k | input | 1 | Line format select: 1 = 7 bits per octet, 0 = 8 bits per octet |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte of a frame |
| in_ready | output | 1 | Payload byte accepted when high together with in_valid |
| out_valid | output | 1 | Raw line octet valid |
| out_data | output | 8 | Raw line octet |
| out_ready | input | 1 | Consumer takes the octet when high together with out_valid |

## Verification
The bench sweeps every single-byte payload in both line formats. This covers stuffing runs that cross byte boundaries and that carry from the payload into the check sequence. A stuffer that counted flag bits, or that dropped its run count between bytes, would corrupt some of these frames. The sweep also produces frames that end aligned and frames that end with a partial octet. A design that always appended the padding octets, or never did, would misplace the start of the following frame. Random backpressure checks that held octets are not lost. Changing the mode in the middle of a frame exposes a design that samples the mode continuously instead of once per frame, because the rest of that frame would switch octet width.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam logic [7:0] HDLC_FLAG = 8'h7E;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_NEXT,
        ST_FCS,
        ST_CLOSE,
        ST_PAD,
        ST_EXTRA
    } tx_state_e;

endpackage

// File: rtl/hdlc_crc_step.sv
module hdlc_crc_step #(
    parameter int                 CRC_W    = 16,
    parameter logic [CRC_W-1:0]   CRC_POLY = 16'h8408
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_out
);
    logic feedback;

    always_comb begin
        feedback = crc_in[0] ^ bit_in;
        crc_out  = (crc_in >> 1) ^ (feedback ? CRC_POLY : '0);
    end
endmodule

// File: rtl/hdlc_run_limiter.sv
module hdlc_run_limiter #(
    parameter int STUFF_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic take,
    input  logic adv,
    input  logic bit_in,
    output logic due
);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    logic [RUN_W-1:0] ones_q;

    assign due = (ones_q == RUN_W'(STUFF_RUN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (clear || take) begin
            ones_q <= '0;
        end else if (adv) begin
            ones_q <= bit_in ? ones_q + RUN_W'(1) : '0;
        end
    end

    // the run of ones never grows past the stuffing threshold
    assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= RUN_W'(STUFF_RUN));

    // while a zero is owed, the controller must not send a data bit
    assert_stuff_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        due |-> !adv);
endmodule

// File: rtl/hdlc_octet_packer.sv
module hdlc_octet_packer #(
    parameter int OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             narrow,
    input  logic             push,
    input  logic             bit_in,
    input  logic             flush,
    input  logic             fill,
    input  logic             take,
    output logic             o_valid,
    output logic [OCT_W-1:0] o_data,
    output logic             room,
    output logic             partial
);
    localparam int CNT_W = $clog2(OCT_W + 1);

    logic [OCT_W-1:0]   acc_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   lim;
    logic [OCT_W-1:0]   nacc;
    logic [2*OCT_W-1:0] wide;
    logic [OCT_W-1:0]   padded;
    logic [OCT_W-1:0]   full_oct;

    assign room    = !o_valid || take;
    assign partial = (cnt_q != '0);

    always_comb begin
        lim      = narrow ? CNT_W'(OCT_W - 1) : CNT_W'(OCT_W);
        nacc     = {bit_in, acc_q[OCT_W-1:1]};
        full_oct = narrow ? {1'b1, nacc[OCT_W-1:1]} : nacc;
        wide     = {{OCT_W{1'b1}}, acc_q} >> (CNT_W'(OCT_W) - cnt_q);
        padded   = wide[OCT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            o_data  <= '1;
            o_valid <= 1'b0;
        end else begin
            if (o_valid && take) begin
                o_valid <= 1'b0;
            end
            if (room) begin
                if (push) begin
                    acc_q <= nacc;
                    if (cnt_q + CNT_W'(1) == lim) begin
                        o_data  <= full_oct;
                        o_valid <= 1'b1;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end else if (flush) begin
                    o_data  <= padded;
                    o_valid <= 1'b1;
                    cnt_q   <= '0;
                end else if (fill) begin
                    o_data  <= '1;
                    o_valid <= 1'b1;
                end
            end
        end
    end

    // an offered octet is held unchanged until the consumer takes it
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !take) |=> (o_valid && $stable(o_data)));
endmodule

// File: rtl/hdlc_stuff_framer.sv
module hdlc_stuff_framer
    import hdlc_tx_pkg::*;
#(
    parameter int               OCT_W     = 8,
    parameter int               CRC_W     = 16,
    parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408,
    parameter int               STUFF_RUN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_56k,
    input  logic             in_valid,
    input  logic [OCT_W-1:0] in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic [OCT_W-1:0] out_data,
    input  logic             out_ready
);
    localparam int               IDX_W    = $clog2(CRC_W);
    localparam int               BIT_W    = $clog2(OCT_W);
    localparam logic [IDX_W-1:0] OCT_END  = IDX_W'(OCT_W - 1);
    localparam logic [IDX_W-1:0] CRC_END  = IDX_W'(CRC_W - 1);
    localparam logic [CRC_W-1:0] CRC_INIT = '1;
    localparam logic [OCT_W-1:0] FLAG_OCT = OCT_W'(HDLC_FLAG);

    tx_state_e        state_q, state_d;
    logic             mode_q, mode_d;
    logic [OCT_W-1:0] byte_q, byte_d;
    logic             last_q, last_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CRC_W-1:0] crc_q, crc_d;
    logic [CRC_W-1:0] fcs_q, fcs_d;

    logic             pk_push, pk_bit, pk_flush, pk_fill;
    logic             pk_valid, pk_room, pk_partial;
    logic [OCT_W-1:0] pk_data;
    logic             st_clear, st_take, st_adv, stuff_due;
    logic             cur_bit;
    logic [CRC_W-1:0] crc_nx;

    assign cur_bit = byte_q[idx_q[BIT_W-1:0]];

    hdlc_crc_step #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
        .crc_in  (crc_q),
        .bit_in  (cur_bit),
        .crc_out (crc_nx)
    );

    hdlc_run_limiter #(.STUFF_RUN(STUFF_RUN)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (st_clear),
        .take   (st_take),
        .adv    (st_adv),
        .bit_in (pk_bit),
        .due    (stuff_due)
    );

    hdlc_octet_packer #(.OCT_W(OCT_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .narrow  (mode_q),
        .push    (pk_push),
        .bit_in  (pk_bit),
        .flush   (pk_flush),
        .fill    (pk_fill),
        .take    (out_ready),
        .o_valid (pk_valid),
        .o_data  (pk_data),
        .room    (pk_room),
        .partial (pk_partial)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            byte_q  <= '0;
            last_q  <= 1'b0;
            idx_q   <= '0;
            crc_q   <= CRC_INIT;
            fcs_q   <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            byte_q  <= byte_d;
            last_q  <= last_d;
            idx_q   <= idx_d;
            crc_q   <= crc_d;
            fcs_q   <= fcs_d;
        end
    end

    // transitions and per-state actions
    always_comb begin
        state_d  = state_q;
        mode_d   = mode_q;
        byte_d   = byte_q;
        last_d   = last_q;
        idx_d    = idx_q;
        crc_d    = crc_q;
        fcs_d    = fcs_q;
        pk_push  = 1'b0;
        pk_bit   = 1'b0;
        pk_flush = 1'b0;
        pk_fill  = 1'b0;
        st_clear = 1'b0;
        st_take  = 1'b0;
        st_adv   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && !pk_valid) begin
                    byte_d   = in_data;
                    last_d   = in_last;
                    mode_d   = rate_56k;
                    crc_d    = CRC_INIT;
                    idx_d    = '0;
                    st_clear = 1'b1;
                    state_d  = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (pk_room) begin
                    pk_push = 1'b1;
                    pk_bit  = FLAG_OCT[idx_q[BIT_W-1:0]];
                    if (idx_q == OCT_END) begin
                        idx_d   = '0;
                        state_d = ST_DATA;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (pk_room) begin
                    pk_push = 1'b1;
                    if (stuff_due) begin
                        pk_bit  = 1'b0;
                        st_take = 1'b1;
                    end else begin
                        pk_bit = cur_bit;
                        st_adv = 1'b1;
                        crc_d  = crc_nx;
                        if (idx_q == OCT_END) begin
                            idx_d = '0;
                            if (last_q) begin
                                fcs_d   = ~crc_nx;
                                state_d = ST_FCS;
                            end else begin
                                state_d = ST_NEXT;
                            end
                        end else begin
                            idx_d = idx_q + IDX_W'(1);
                        end
                    end
                end
            end
            ST_NEXT: begin
                if (in_valid) begin
                    byte_d  = in_data;
                    last_d  = in_last;
                    state_d = ST_DATA;
                end
            end
            ST_FCS: begin
                if (pk_room) begin
                    pk_push = 1'b1;
                    if (stuff_due) begin
                        pk_bit  = 1'b0;
                        st_take = 1'b1;
                    end else begin
                        pk_bit = fcs_q[idx_q];
                        st_adv = 1'b1;
                        if (idx_q == CRC_END) begin
                            idx_d   = '0;
                            state_d = ST_CLOSE;
                        end else begin
                            idx_d = idx_q + IDX_W'(1);
                        end
                    end
                end
            end
            ST_CLOSE: begin
                if (pk_room) begin
                    pk_push = 1'b1;
                    if (stuff_due) begin
                        pk_bit  = 1'b0;
                        st_take = 1'b1;
                    end else begin
                        pk_bit = FLAG_OCT[idx_q[BIT_W-1:0]];
                        if (idx_q == OCT_END) begin
                            idx_d   = '0;
                            state_d = ST_PAD;
                        end else begin
                            idx_d = idx_q + IDX_W'(1);
                        end
                    end
                end
            end
            ST_PAD: begin
                if (pk_room) begin
                    if (pk_partial) begin
                        pk_flush = 1'b1;
                        state_d  = ST_EXTRA;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_EXTRA: begin
                if (pk_room) begin
                    pk_fill = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = ((state_q == ST_IDLE) && !pk_valid) || (state_q == ST_NEXT);
        out_valid = pk_valid || ((state_q == ST_IDLE) && !in_valid);
        out_data  = pk_valid ? pk_data : '1;
    end

    // the format is frozen once a frame is under way
    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mode_q));

    // no further payload is taken after the closing byte
    assert_last_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // every octet of a narrow-format frame has its top bit set
    assert_narrow_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && pk_valid && state_q != ST_IDLE) |-> out_data[OCT_W-1]);

    // a frame only begins with an empty output register
    assert_clean_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid && in_ready) |-> !pk_valid);
endmodule

// File: tb/sim_hdlc_stuff_framer.sv
module sim_hdlc_stuff_framer;
    typedef logic [7:0] oq_t[$];

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rate_56k;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_last;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready;

    int    checks = 0;
    int    errors = 0;
    int    aligned_seen = 0;
    int    partial_seen = 0;
    bit    rnd_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    oq_t   expq;
    string tagq[$];

    always #2 clk = ~clk;

    hdlc_stuff_framer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_56k  (rate_56k),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural line model: bit list, then octet packing
    function automatic oq_t model(input oq_t pay, input bit m56);
        int bits[$];
        int ones = 0;
        int crc  = 'hFFFF;
        int acc  = 0;
        int cnt  = 0;
        int lim  = m56 ? 7 : 8;
        int b;
        int fcs;
        oq_t o;
        for (int i = 0; i < 8; i++) bits.push_back((8'h7E >> i) & 1);
        foreach (pay[k]) begin
            for (int i = 0; i < 8; i++) begin
                b = (pay[k] >> i) & 1;
                bits.push_back(b);
                crc = ((crc & 1) ^ b) ? ((crc >> 1) ^ 'h8408) : (crc >> 1);
                ones = b ? ones + 1 : 0;
                if (ones == 5) begin bits.push_back(0); ones = 0; end
            end
        end
        fcs = (~crc) & 'hFFFF;
        for (int i = 0; i < 16; i++) begin
            b = (fcs >> i) & 1;
            bits.push_back(b);
            ones = b ? ones + 1 : 0;
            if (ones == 5) begin bits.push_back(0); ones = 0; end
        end
        for (int i = 0; i < 8; i++) bits.push_back((8'h7E >> i) & 1);
        foreach (bits[k]) begin
            acc = ((acc >> 1) | (bits[k] << 7)) & 'hFF;
            cnt++;
            if (cnt == lim) begin
                o.push_back(m56 ? 8'((acc >> 1) | 'h80) : 8'(acc));
                cnt = 0;
            end
        end
        if (cnt != 0) begin
            partial_seen++;
            o.push_back(8'((acc >> (8 - cnt)) | ('hFF << cnt)));
            o.push_back(8'hFF);
        end else begin
            aligned_seen++;
        end
        return o;
    endfunction

    // consumer ready pattern
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = rnd_en ? lfsr[0] : 1'b1;
        end
    end

    // compare every accepted octet against the model stream
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid && out_ready) begin
            if (expq.size() > 0) begin
                chk(out_data == expq[0], tagq[0], out_data, expq[0]);
                void'(expq.pop_front());
                void'(tagq.pop_front());
            end else begin
                chk(out_data == 8'hFF, "R1 idle filler", out_data, 8'hFF);
            end
        end
    end

    task automatic send(input oq_t pay, input bit m56, input bit flip, input string tag);
        oq_t e;
        bit  got;
        @(posedge clk);
        #1;
        rate_56k = m56;
        e = model(pay, m56);
        foreach (e[k]) begin
            expq.push_back(e[k]);
            tagq.push_back(tag);
        end
        for (int k = 0; k < pay.size(); k++) begin
            in_valid = 1'b1;
            in_data  = pay[k];
            in_last  = (k == pay.size() - 1);
            do begin
                @(negedge clk);
                got = in_ready;
                @(posedge clk);
            end while (!got);
            #1;
            if (flip && k == 0) rate_56k = !m56;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b0, "R10 no input after last", in_ready, 0);
    endtask

    task automatic drain();
        int w = 0;
        while (expq.size() > 0 && w < 5000) begin
            @(posedge clk);
            w++;
        end
        chk(expq.size() == 0, "R9 all octets delivered", expq.size(), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b1 && out_data == 8'hFF, "R1 idle output", out_data, 8'hFF);
        chk(in_ready == 1'b1, "R1 idle ready", in_ready, 1);
    endtask

    initial begin
        oq_t f;
        rst_n    = 1'b0;
        rate_56k = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        in_last  = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b1, "R1 reset valid", out_valid, 1);
        chk(out_data == 8'hFF, "R1 reset data", out_data, 8'hFF);
        chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);

        f = '{8'h00};
        send(f, 1'b0, 1'b0, "R2 R3 R5 R7 single zero byte");
        drain();
        f = '{8'hFF, 8'hFF, 8'h7E};
        send(f, 1'b0, 1'b0, "R4 R5 R3 ones runs");
        drain();
        f = '{8'h12, 8'h34, 8'hFF};
        send(f, 1'b1, 1'b0, "R6 R4 narrow format");
        drain();

        rnd_en = 1'b1;
        f = '{8'hA5, 8'h5A, 8'hF0};
        send(f, 1'b0, 1'b1, "R8 mode flip wide");
        f = '{8'h3C, 8'hFF, 8'h01, 8'h80};
        send(f, 1'b1, 1'b1, "R8 R6 mode flip narrow");
        drain();

        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 256; v++) begin
                f = '{8'(v)};
                send(f, m[0], 1'b0, "R3 R4 R5 R7 R9 sweep");
            end
        end
        drain();
        chk(aligned_seen > 0, "R7 aligned frame exercised", aligned_seen, 1);
        chk(partial_seen > 0, "R7 partial frame exercised", partial_seen, 1);

        f = {};
        for (int i = 0; i < 24; i++) f.push_back(8'(i * 37 + 11));
        send(f, 1'b1, 1'b0, "R6 R9 long narrow frame");
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired act=%0d exp=%0d", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule